// File: doc/BRIEF.md
# Four-Channel DMA Request Dispatcher

This block sits between the trigger sources of a chip and a DMA transfer engine. It listens to single-cycle event strobes from six sources: an external pin, the transmit-empty and receive-full events of two serial ports, and a timer tick. It then decides which of four DMA channels each event belongs to. A channel belongs to an event through the 4-bit resource code that software has set for it.

Each channel also has an enable bit and a transfer-end bit, and a 3-bit global mode field gates the whole block. Every event that matches an active channel adds one unit to that channel's pending count. The channel offers one transfer request per pending unit to the transfer engine over a per-channel valid/ready pair.

Channels that are set to auto-request hold their request up without waiting for any event. This lets the engine stream them until software stops them. When one event matches several channels, every one of those channels gains a unit. Events that arrive in the same cycle are combined, so none is dropped.

Top module: `dma_req_dispatch`

Each channel's request port follows valid/ready rules. `req_valid[i]` stays high and does not fall until the engine accepts the request with `req_ready[i]` in the same cycle, or until the channel becomes inactive. Each accepted handshake uses up exactly one pending unit. `req_ready` has no effect while `req_valid` is low.

## Requirements
- R1: After reset, every bit of `req_valid` is 0 and no channel holds a pending unit.
- R2: While `glb_mode` is not 3'b001, `req_valid` is all zero and events are not counted. Units that were pending when the mode left 3'b001 are discarded, and returning to 3'b001 does not restore them.
- R3: A pulse on `trg_pin` adds a unit only to active channels whose resource code is 4'h0.
- R4: Serial port A transmit-empty matches code 4'h8 and its receive-full matches 4'h9. Serial port B transmit-empty matches 4'hA and its receive-full matches 4'hB.
- R5: A pulse on `trg_timer` adds a unit to every active channel whose code is 4'hC through 4'hF, so one pulse can serve several channels.
- R6: Each matching event adds exactly one unit. A channel whose count is non-zero shows `req_valid` high in the cycle after the event's clock edge, and the number of accepted handshakes equals the number of events.
- R7: An active channel with code 4'h4, 4'h5 or 4'h6 holds `req_valid` high without any event, and accepting handshakes does not lower it.
- R8: A channel with `ch_en` clear or `ch_end` set never asserts `req_valid`, and the units it holds are discarded.
- R9: Events that arrive in the same cycle for different channels are all recorded.
- R10: A unit stays pending until it is accepted. When a handshake and a new matching event fall on the same clock edge, the count is unchanged.
- R11: The pending count saturates at 2**PEND_W-1 (7 by default), and further events are dropped.
- R12: Codes 4'h1, 4'h2, 4'h3 and 4'h7 never produce requests from any event.
- R13: The resource code of channel i is `ch_res[4*i+3:4*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_mode | input | 3 | Global mode field; 3'b001 enables dispatch |
| ch_en | input | 4 | Per-channel enable |
| ch_end | input | 4 | Per-channel transfer-end flag |
| ch_res | input | 16 | Resource codes, 4 bits per channel |
| trg_pin | input | 1 | External pin event strobe |
| trg_sa_txe | input | 1 | Serial port A transmit-empty strobe |
| trg_sa_rxf | input | 1 | Serial port A receive-full strobe |
| trg_sb_txe | input | 1 | Serial port B transmit-empty strobe |
| trg_sb_rxf | input | 1 | Serial port B receive-full strobe |
| trg_timer | input | 1 | Timer event strobe |
| req_valid | output | 4 | Per-channel transfer request |
| req_ready | input | 4 | Per-channel request acceptance |

## Verification
The two functions that can share one cycle are the acceptance of a pending unit and the arrival of a new matching event on the same channel. The bench leaves one unit pending, then raises `req_ready` and pulses the trigger before the same clock edge. It then judges the result by checking that `req_valid` is still high and that exactly one further handshake drains the channel. A second overlap fires events for four different channels together and expects every channel to request once.

// File: rtl/dmadisp_pkg.sv
package dmadisp_pkg;
  localparam int RES_W   = 4;
  localparam int NUM_TRG = 6;

  typedef enum logic [2:0] {
    TRG_PIN   = 3'd0,
    TRG_SATX  = 3'd1,
    TRG_SARX  = 3'd2,
    TRG_SBTX  = 3'd3,
    TRG_SBRX  = 3'd4,
    TRG_TIMER = 3'd5
  } trg_idx_e;

  localparam logic [2:0]       GLB_ON    = 3'b001;
  localparam logic [RES_W-1:0] CODE_PIN  = 4'h0;
  localparam logic [RES_W-1:0] CODE_SATX = 4'h8;
  localparam logic [RES_W-1:0] CODE_SARX = 4'h9;
  localparam logic [RES_W-1:0] CODE_SBTX = 4'hA;
  localparam logic [RES_W-1:0] CODE_SBRX = 4'hB;
  localparam logic [RES_W-1:0] CODE_TMR0 = 4'hC;
  localparam logic [RES_W-1:0] CODE_AUT0 = 4'h4;
  localparam logic [RES_W-1:0] CODE_AUT1 = 4'h6;
endpackage

// File: rtl/dmadisp_decode.sv
module dmadisp_decode
  import dmadisp_pkg::*;
(
  input  logic [RES_W-1:0]   code,
  input  logic [NUM_TRG-1:0] trg,
  output logic               hit,
  output logic               auto_mode
);
  logic [NUM_TRG-1:0] sel;

  always_comb begin
    sel = '0;
    sel[TRG_PIN]   = (code == CODE_PIN);
    sel[TRG_SATX]  = (code == CODE_SATX);
    sel[TRG_SARX]  = (code == CODE_SARX);
    sel[TRG_SBTX]  = (code == CODE_SBTX);
    sel[TRG_SBRX]  = (code == CODE_SBRX);
    sel[TRG_TIMER] = (code >= CODE_TMR0);
  end

  // Each code selects at most one class; OR folds simultaneous events.
  assign hit       = |(sel & trg);
  assign auto_mode = (code >= CODE_AUT0) && (code <= CODE_AUT1);
endmodule

// File: rtl/dmadisp_pend.sv
module dmadisp_pend #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic auto_mode,
  input  logic hit,
  input  logic ready,
  output logic valid
);
  localparam logic [PEND_W-1:0] CNT_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] cnt;
  logic              take;

  assign valid = active && (auto_mode || (cnt != '0));
  assign take  = valid && ready && !auto_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!active || auto_mode) begin
      cnt <= '0;
    end else begin
      case ({hit, take})
        2'b10:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8
  inactive_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));

  // R6
  take_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !auto_mode && valid && ready && !hit) |=> (cnt == $past(cnt) - 1'b1));

  // R10
  hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !auto_mode && !ready) |=> (cnt >= $past(cnt)));

  // R11
  sat_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !auto_mode && cnt == CNT_MAX && hit && !ready) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/dma_req_dispatch.sv
module dma_req_dispatch
  import dmadisp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PEND_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              glb_mode,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH-1:0]       ch_end,
  input  logic [NUM_CH*RES_W-1:0] ch_res,
  input  logic                    trg_pin,
  input  logic                    trg_sa_txe,
  input  logic                    trg_sa_rxf,
  input  logic                    trg_sb_txe,
  input  logic                    trg_sb_rxf,
  input  logic                    trg_timer,
  output logic [NUM_CH-1:0]       req_valid,
  input  logic [NUM_CH-1:0]       req_ready
);
  logic [NUM_TRG-1:0] trg;
  logic               glb_on;

  always_comb begin
    trg = '0;
    trg[TRG_PIN]   = trg_pin;
    trg[TRG_SATX]  = trg_sa_txe;
    trg[TRG_SARX]  = trg_sa_rxf;
    trg[TRG_SBTX]  = trg_sb_txe;
    trg[TRG_SBRX]  = trg_sb_rxf;
    trg[TRG_TIMER] = trg_timer;
  end

  assign glb_on = (glb_mode == GLB_ON);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit, auto_mode, active;

    assign active = glb_on && ch_en[i] && !ch_end[i];

    dmadisp_decode u_dec (
      .code      (ch_res[i*RES_W +: RES_W]),
      .trg       (trg),
      .hit       (hit),
      .auto_mode (auto_mode)
    );

    dmadisp_pend #(.PEND_W(PEND_W)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .auto_mode (auto_mode),
      .hit       (hit),
      .ready     (req_ready[i]),
      .valid     (req_valid[i])
    );
  end

  // R2
  glb_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_mode != GLB_ON) |-> (req_valid == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (req_valid == '0));
endmodule

// File: tb/dma_req_dispatch_tb.sv
module dma_req_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  glb_mode = 3'b000;
  logic [3:0]  ch_en = '0, ch_end = '0, req_ready = '0;
  logic [15:0] ch_res = '0;
  logic [5:0]  trg = '0;
  logic [3:0]  req_valid;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dma_req_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .glb_mode(glb_mode), .ch_en(ch_en),
    .ch_end(ch_end), .ch_res(ch_res), .trg_pin(trg[0]),
    .trg_sa_txe(trg[1]), .trg_sa_rxf(trg[2]), .trg_sb_txe(trg[3]),
    .trg_sb_rxf(trg[4]), .trg_timer(trg[5]),
    .req_valid(req_valid), .req_ready(req_ready)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Flush all channels, then program codes (ch3..ch0) and enable all.
  task automatic setup(logic [15:0] codes);
    @(negedge clk);
    ch_en = '0; ch_end = '0; req_ready = '0; trg = '0;
    @(negedge clk);
    ch_res = codes; glb_mode = 3'b001; ch_en = 4'hF;
    @(negedge clk);
  endtask

  task automatic pulse(logic [5:0] t);
    trg = t;
    @(negedge clk);
    trg = '0;
  endtask

  task automatic drain(int ch, output int n);
    n = 0;
    req_ready[ch] = 1'b1;
    repeat (20) begin
      if (req_valid[ch]) n++;
      @(negedge clk);
    end
    req_ready[ch] = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset valid", req_valid, 0);
  endtask

  task automatic t_pin();
    int n;
    setup(16'hC_1_8_0);
    pulse(6'b000001);
    check("R3 pin routes code 0 (R13 ch0 lane)", req_valid, 4'b0001);
    drain(0, n);
    check("R3 pin single unit", n, 1);
  endtask

  task automatic t_serial();
    int n;
    setup(16'hB_A_9_8);
    for (int k = 0; k < 4; k++) begin
      pulse(6'b000010 << k);
      check("R4 serial class routing", req_valid, 1 << k);
      drain(k, n);
      check("R4 serial unit count", n, 1);
    end
  endtask

  task automatic t_timer();
    setup(16'h0_E_F_C);
    pulse(6'b100000);
    check("R5 timer range fan-out", req_valid, 4'b0111);
  endtask

  task automatic t_unused();
    setup(16'h7_3_2_1);
    pulse(6'b111111);
    check("R12 unused codes silent", req_valid, 0);
  endtask

  task automatic t_count();
    int n;
    setup(16'h1_1_1_0);
    repeat (3) pulse(6'b000001);
    check("R6 valid after events", req_valid, 4'b0001);
    drain(0, n);
    check("R6 handshakes equal events", n, 3);
  endtask

  task automatic t_auto();
    setup(16'h7_6_5_4);
    check("R7 auto without trigger", req_valid, 4'b0111);
    req_ready = 4'hF;
    repeat (5) @(negedge clk);
    check("R7 auto holds through handshakes", req_valid, 4'b0111);
    req_ready = '0;
  endtask

  task automatic t_gate();
    setup(16'h1_1_1_0);
    glb_mode = 3'b011;
    @(negedge clk);
    pulse(6'b000001);
    check("R2 global off blocks", req_valid, 0);
    glb_mode = 3'b001;
    @(negedge clk);
    check("R2 events while off not kept", req_valid, 0);
    pulse(6'b000001);
    glb_mode = 3'b000;
    @(negedge clk);
    glb_mode = 3'b001;
    @(negedge clk);
    check("R2 pending discarded when off", req_valid, 0);
    ch_en[0] = 1'b0;
    pulse(6'b000001);
    check("R8 disabled channel silent", req_valid, 0);
    ch_en[0] = 1'b1;
    pulse(6'b000001);
    ch_end[0] = 1'b1;
    @(negedge clk);
    check("R8 ended channel silent", req_valid, 0);
    ch_end[0] = 1'b0;
    @(negedge clk);
    check("R8 pending discarded", req_valid, 0);
  endtask

  task automatic t_simul();
    int n;
    setup(16'hB_C_8_0);
    pulse(6'b110011);
    check("R9 simultaneous events", req_valid, 4'b1111);
    for (int k = 0; k < 4; k++) begin
      drain(k, n);
      check("R9 one unit each", n, 1);
    end
  endtask

  task automatic t_overlap();
    int n;
    setup(16'h1_1_1_0);
    pulse(6'b000001);
    req_ready[0] = 1'b1;
    pulse(6'b000001);
    req_ready[0] = 1'b0;
    check("R10 handshake plus event keeps valid", req_valid, 4'b0001);
    drain(0, n);
    check("R10 one unit left", n, 1);
  endtask

  task automatic t_sat();
    int n;
    setup(16'h1_1_1_0);
    repeat (9) pulse(6'b000001);
    drain(0, n);
    check("R11 saturation at 7", n, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pin();
    t_serial();
    t_timer();
    t_unused();
    t_count();
    t_auto();
    t_gate();
    t_simul();
    t_overlap();
    t_sat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule